// File: doc/BRIEF.md
# Skip-Controlled Accumulator Processor

This block is a compact single-accumulator processor for a teaching machine. Program and data sit together in a 100-word memory inside the block. Every instruction goes through a fixed multi-cycle sequence. In the fetch steps the program counter goes to the memory address register, the addressed word goes to the memory data register, and that word then goes to the instruction register while the program counter steps by one. The execute steps then carry out the instruction. Arithmetic always uses the accumulator and one memory word, and the result always returns to the accumulator.

The block has no conditional branch. A skip instruction steps over the next word when the accumulator is non-negative, or when it is exactly zero. An unconditional jump placed after the skip then builds the loop or the exit. A preload port fills the memory while the block is held in reset. Numbers come in through a valid/ready input port and leave through an output port with a one-cycle strobe. A sticky flag shows that the program has stopped.

Top module: `skipacc_core`

## Requirements
- R1: While rst_n is low, halted, out_valid and in_ready are all low, the program counter is cleared, and the first instruction is fetched from address 0.
- R2: An instruction word is 12 bits. The opcode is in bits 11:8 and the operand address is in bits 6:0. The opcodes are 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 input, 6 output, 7 jump, 8 skip-if-non-negative and 9 skip-if-zero. Opcodes 10 to 15, and any word with bit 7 set, behave as halt.
- R3: Every instruction starts with three fetch cycles, and the next instruction starts on the following cycle. Load, add and subtract take 6 cycles in total, store takes 5, and jump, skip and output take 4. Input takes 4 cycles plus one cycle for each cycle spent waiting.
- R4: Load copies the addressed word into the accumulator. Add and subtract combine the accumulator with the addressed word as 12-bit two's complement numbers and wrap on overflow.
- R5: Store writes the accumulator into the addressed word. A later load of that address returns the value written.
- R6: Jump loads the program counter from the address field.
- R7: Skip-if-non-negative steps over the next word when accumulator bit 11 is 0. It does nothing when bit 11 is 1.
- R8: Skip-if-zero steps over the next word only when the accumulator is 0.
- R9: in_ready is high only during the execute cycle of an input instruction. That cycle repeats until in_valid is high, and in_data is then loaded into the accumulator. in_valid has no effect at any other time.
- R10: Output raises out_valid for exactly one cycle. This is the cycle after the instruction's fourth cycle, and out_data then holds the accumulator value.
- R11: After the execute cycle of a halt, halted goes high and stays high until reset. From then on there are no more fetches, no out_valid and no in_ready.
- R12: The memory holds addresses 0 to 99. Reads from addresses 100 to 127 return 0, so a fetch there halts. Preload or store writes to those addresses are dropped. When load_en is high, load_data is written to load_addr.
- R13: rst_n is released through a two-stage synchronizer. The first fetch transfer happens on the third rising edge after rst_n goes high, so a program that starts with an input instruction raises in_ready after the fifth rising edge.
- R14: A preloaded program counts how many times the second input can be subtracted from the first. With inputs 8 and 5 it outputs 1 and then halts. With inputs 17 and 5 it outputs 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Memory preload write enable |
| load_addr | input | 7 | Memory preload address |
| load_data | input | 12 | Memory preload word |
| in_data | input | 12 | Input port value |
| in_valid | input | 1 | Input value available |
| in_ready | output | 1 | Processor waiting for an input value |
| out_data | output | 12 | Last output value |
| out_valid | output | 1 | One-cycle strobe for out_data |
| halted | output | 1 | Sticky stop flag |

## Verification
The in-RTL properties check the following on every cycle:
- the program counter steps by one at the end of fetch;
- a jump lands on the address field;
- a skip leaves the program counter alone when its condition is false;
- the output strobe never lasts two cycles;
- the halt flag never drops;
- the accumulator holds still while an input instruction waits.

Only the bench scenarios can show the rest. These are the exact cycle counts of each instruction class, the arithmetic results and their wrap, the round trip through memory by store and load, the dropped writes above address 99, and the complete counting and countdown programs.

// File: rtl/skipacc_pkg.sv
package skipacc_pkg;

  localparam int unsigned OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_HLT = 4'd0;
  localparam logic [OPC_W-1:0] OPC_LDA = 4'd1;
  localparam logic [OPC_W-1:0] OPC_STA = 4'd2;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'd3;
  localparam logic [OPC_W-1:0] OPC_SUB = 4'd4;
  localparam logic [OPC_W-1:0] OPC_IN  = 4'd5;
  localparam logic [OPC_W-1:0] OPC_OUT = 4'd6;
  localparam logic [OPC_W-1:0] OPC_JMP = 4'd7;
  localparam logic [OPC_W-1:0] OPC_SKP = 4'd8;
  localparam logic [OPC_W-1:0] OPC_SKZ = 4'd9;

  typedef enum logic [2:0] {
    ST_FETCH_A,
    ST_FETCH_B,
    ST_FETCH_C,
    ST_EXEC_A,
    ST_EXEC_B,
    ST_EXEC_C,
    ST_HALT
  } seq_state_e;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB
  } alu_fn_e;

  typedef enum logic {
    ACC_FROM_ALU,
    ACC_FROM_PORT
  } acc_src_e;

endpackage

// File: rtl/skipacc_mem.sv
module skipacc_mem #(
  parameter int WORD_W = 12,
  parameter int ADDR_W = 7,
  parameter int DEPTH  = 100
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [WORD_W-1:0] cells [DEPTH];
  logic              wr_in_range;
  logic              rd_in_range;

  generate
    if (DEPTH < (1 << ADDR_W)) begin : g_partial
      assign wr_in_range = (wr_addr <= LAST_ADDR);
      assign rd_in_range = (rd_addr <= LAST_ADDR);
    end else begin : g_full
      assign wr_in_range = 1'b1;
      assign rd_in_range = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_en && wr_in_range) begin
      cells[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_in_range) begin
      rd_data = cells[rd_addr];
    end
  end

endmodule

// File: rtl/skipacc_alu.sv
module skipacc_alu
  import skipacc_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  alu_fn_e           fn,
  input  logic [WORD_W-1:0] acc_val,
  input  logic [WORD_W-1:0] mem_val,
  output logic [WORD_W-1:0] result
);

  always_comb begin
    case (fn)
      ALU_ADD: result = acc_val + mem_val;
      ALU_SUB: result = acc_val - mem_val;
      default: result = mem_val;
    endcase
  end

endmodule

// File: rtl/skipacc_seq.sv
module skipacc_seq
  import skipacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opc,
  input  logic             rsvd_set,
  input  logic             acc_neg,
  input  logic             acc_zero,
  input  logic             in_valid,
  output seq_state_e       state,
  output logic             ld_mar_pc,
  output logic             ld_mar_ir,
  output logic             ld_mdr,
  output logic             ld_ir,
  output logic             inc_pc,
  output logic             jmp_pc,
  output logic             ld_acc,
  output acc_src_e         acc_src,
  output alu_fn_e          alu_fn,
  output logic             mem_we,
  output logic             ld_out,
  output logic             in_ready,
  output logic             halted
);

  seq_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    ld_mar_pc = 1'b0;
    ld_mar_ir = 1'b0;
    ld_mdr    = 1'b0;
    ld_ir     = 1'b0;
    inc_pc    = 1'b0;
    jmp_pc    = 1'b0;
    ld_acc    = 1'b0;
    acc_src   = ACC_FROM_ALU;
    alu_fn    = ALU_PASS;
    mem_we    = 1'b0;
    ld_out    = 1'b0;
    in_ready  = 1'b0;
    case (state)
      ST_FETCH_A: begin
        ld_mar_pc = 1'b1;
        state_nxt = ST_FETCH_B;
      end
      ST_FETCH_B: begin
        ld_mdr    = 1'b1;
        state_nxt = ST_FETCH_C;
      end
      ST_FETCH_C: begin
        ld_ir     = 1'b1;
        inc_pc    = 1'b1;
        state_nxt = ST_EXEC_A;
      end
      ST_EXEC_A: begin
        state_nxt = ST_HALT;
        if (!rsvd_set) begin
          case (opc)
            OPC_LDA, OPC_STA, OPC_ADD, OPC_SUB: begin
              ld_mar_ir = 1'b1;
              state_nxt = ST_EXEC_B;
            end
            OPC_IN: begin
              in_ready  = 1'b1;
              state_nxt = ST_EXEC_A;
              if (in_valid) begin
                ld_acc    = 1'b1;
                acc_src   = ACC_FROM_PORT;
                state_nxt = ST_FETCH_A;
              end
            end
            OPC_OUT: begin
              ld_out    = 1'b1;
              state_nxt = ST_FETCH_A;
            end
            OPC_JMP: begin
              jmp_pc    = 1'b1;
              state_nxt = ST_FETCH_A;
            end
            OPC_SKP: begin
              inc_pc    = !acc_neg;
              state_nxt = ST_FETCH_A;
            end
            OPC_SKZ: begin
              inc_pc    = acc_zero;
              state_nxt = ST_FETCH_A;
            end
            default: state_nxt = ST_HALT;
          endcase
        end
      end
      ST_EXEC_B: begin
        if (opc == OPC_STA) begin
          mem_we    = 1'b1;
          state_nxt = ST_FETCH_A;
        end else begin
          ld_mdr    = 1'b1;
          state_nxt = ST_EXEC_C;
        end
      end
      ST_EXEC_C: begin
        ld_acc    = 1'b1;
        state_nxt = ST_FETCH_A;
        if (opc == OPC_ADD) begin
          alu_fn = ALU_ADD;
        end else if (opc == OPC_SUB) begin
          alu_fn = ALU_SUB;
        end
      end
      default: state_nxt = ST_HALT;
    endcase
  end

  assign halted = (state == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH_A;
    end else begin
      state <= state_nxt;
    end
  end

  AST_READY_NOT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !halted);  // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);  // R11

endmodule

// File: rtl/skipacc_core.sv
module skipacc_core #(
  parameter int WORD_W    = 12,
  parameter int ADDR_W    = 7,
  parameter int MEM_DEPTH = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WORD_W-1:0] load_data,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              halted
);

  import skipacc_pkg::*;

  localparam int OPC_LSB = WORD_W - OPC_W;

  logic [1:0]        rst_sync;
  logic              rst_core_n;

  logic [ADDR_W-1:0] pc, pc_nxt, mar, mar_nxt;
  logic [WORD_W-1:0] mdr, ir, acc, acc_nxt;
  logic              pc_en, mar_en;

  logic [WORD_W-1:0] mem_rdata, alu_y;
  logic              mem_wr_en;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [WORD_W-1:0] mem_wr_data;

  logic [OPC_W-1:0]  opc;
  logic              rsvd_set;
  logic              acc_neg, acc_zero;

  seq_state_e        seq_state;
  logic              ld_mar_pc, ld_mar_ir, ld_mdr, ld_ir;
  logic              inc_pc, jmp_pc, ld_acc, mem_we, ld_out;
  acc_src_e          acc_src;
  alu_fn_e           alu_fn;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[1];

  assign opc      = ir[WORD_W-1:OPC_LSB];
  assign acc_neg  = acc[WORD_W-1];
  assign acc_zero = (acc == '0);

  generate
    if (OPC_LSB > ADDR_W) begin : g_rsvd
      assign rsvd_set = |ir[OPC_LSB-1:ADDR_W];
    end else begin : g_no_rsvd
      assign rsvd_set = 1'b0;
    end
  endgenerate

  skipacc_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .opc       (opc),
    .rsvd_set  (rsvd_set),
    .acc_neg   (acc_neg),
    .acc_zero  (acc_zero),
    .in_valid  (in_valid),
    .state     (seq_state),
    .ld_mar_pc (ld_mar_pc),
    .ld_mar_ir (ld_mar_ir),
    .ld_mdr    (ld_mdr),
    .ld_ir     (ld_ir),
    .inc_pc    (inc_pc),
    .jmp_pc    (jmp_pc),
    .ld_acc    (ld_acc),
    .acc_src   (acc_src),
    .alu_fn    (alu_fn),
    .mem_we    (mem_we),
    .ld_out    (ld_out),
    .in_ready  (in_ready),
    .halted    (halted)
  );

  skipacc_alu #(.WORD_W(WORD_W)) i_alu (
    .fn      (alu_fn),
    .acc_val (acc),
    .mem_val (mdr),
    .result  (alu_y)
  );

  // preload port has priority over a store in the same cycle
  always_comb begin
    mem_wr_en   = load_en | mem_we;
    mem_wr_addr = load_en ? load_addr : mar;
    mem_wr_data = load_en ? load_data : acc;
  end

  skipacc_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DEPTH(MEM_DEPTH)) i_mem (
    .clk     (clk),
    .wr_en   (mem_wr_en),
    .wr_addr (mem_wr_addr),
    .wr_data (mem_wr_data),
    .rd_addr (mar),
    .rd_data (mem_rdata)
  );

  always_comb begin
    pc_en   = inc_pc | jmp_pc;
    pc_nxt  = jmp_pc ? ir[ADDR_W-1:0] : pc + 1'b1;
    mar_en  = ld_mar_pc | ld_mar_ir;
    mar_nxt = ld_mar_ir ? ir[ADDR_W-1:0] : pc;
    acc_nxt = (acc_src == ACC_FROM_PORT) ? in_data : alu_y;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pc        <= '0;
      mar       <= '0;
      mdr       <= '0;
      ir        <= '0;
      acc       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (pc_en)  pc  <= pc_nxt;
      if (mar_en) mar <= mar_nxt;
      if (ld_mdr) mdr <= mem_rdata;
      if (ld_ir)  ir  <= mdr;
      if (ld_acc) acc <= acc_nxt;
      if (ld_out) out_data <= acc;
      out_valid <= ld_out;
    end
  end

  AST_FETCH_STEPS_PC: assert property (@(posedge clk) disable iff (!rst_core_n)
    (seq_state == ST_FETCH_C) |=> (pc == $past(pc) + 1'b1));  // R3
  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_core_n)
    (seq_state == ST_EXEC_A && opc == OPC_JMP && !rsvd_set) |=> (pc == $past(ir[ADDR_W-1:0])));  // R6
  AST_SKP_NEG_HOLDS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (seq_state == ST_EXEC_A && opc == OPC_SKP && !rsvd_set && acc[WORD_W-1]) |=> $stable(pc));  // R7
  AST_SKZ_NONZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (seq_state == ST_EXEC_A && opc == OPC_SKZ && !rsvd_set && acc != '0) |=> $stable(pc));  // R8
  AST_WAIT_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_ready && !in_valid) |=> $stable(acc));  // R9
  AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid |=> !out_valid);  // R10

endmodule

// File: tb/test_skipacc_core.sv
module test_skipacc_core;

  localparam int W     = 12;
  localparam int AW    = 7;
  localparam int DEPTH = 100;
  localparam int IMG   = 128;

  localparam int K_HLT = 0, K_LDA = 1, K_STA = 2, K_ADD = 3, K_SUB = 4;
  localparam int K_IN = 5, K_OUT = 6, K_JMP = 7, K_SKP = 8, K_SKZ = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_en = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [W-1:0]  load_data = '0;
  logic [W-1:0]  in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready, out_valid, halted;
  logic [W-1:0]  out_data;

  skipacc_core i_skipacc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_addr (load_addr),
    .load_data (load_data),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .halted    (halted)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int total_cycles = 0;
  bit done = 1'b0;

  int img [IMG];
  int m_mem [DEPTH];
  int m_pc, m_acc, m_cyc, m_word, m_opnd, m_since, m_od;
  bit m_halt, m_ov, took, cmp_en;
  int in_q [$];
  int in_gap_cfg, in_gap;
  int got [$];
  int exp_q [$];

  function automatic int enc(int op, int a);
    return (op << 8) | a;
  endfunction

  task automatic chk(bit ok, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  function automatic bit exp_ready();
    return !m_halt && m_cyc == 3 && ((m_word >> 8) & 15) == K_IN && ((m_word >> 7) & 1) == 0;
  endfunction

  // behavioural reference: one instruction-level machine with a cycle counter
  function automatic void m_step();
    int op = (m_word >> 8) & 15;
    int a  = m_word & 127;
    bit rs = (m_word >> 7) & 1;
    case (m_cyc)
      0: m_cyc = 1;
      1: m_cyc = 2;
      2: begin
        m_word = (m_pc < DEPTH) ? m_mem[m_pc] : 0;
        m_pc = (m_pc + 1) % 128;
        m_cyc = 3;
      end
      3: begin
        if (rs || op == K_HLT || op > K_SKZ) m_halt = 1'b1;
        else if (op == K_IN) begin
          if (in_valid) begin m_acc = int'(in_data); took = 1'b1; m_cyc = 0; end
        end else if (op == K_OUT) begin m_ov = 1'b1; m_od = m_acc; m_cyc = 0; end
        else if (op == K_JMP) begin m_pc = a; m_cyc = 0; end
        else if (op == K_SKP) begin
          if ((m_acc & 'h800) == 0) m_pc = (m_pc + 1) % 128;
          m_cyc = 0;
        end else if (op == K_SKZ) begin
          if (m_acc == 0) m_pc = (m_pc + 1) % 128;
          m_cyc = 0;
        end else m_cyc = 4;
      end
      4: begin
        if (op == K_STA) begin
          if (a < DEPTH) m_mem[a] = m_acc;
          m_cyc = 0;
        end else begin
          m_opnd = (a < DEPTH) ? m_mem[a] : 0;
          m_cyc = 5;
        end
      end
      default: begin
        if (op == K_LDA) m_acc = m_opnd;
        else if (op == K_ADD) m_acc = (m_acc + m_opnd) & 'hFFF;
        else m_acc = (m_acc - m_opnd) & 'hFFF;
        m_cyc = 0;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    total_cycles++;
    if (!rst_n) begin
      m_pc = 0; m_acc = 0; m_cyc = 0; m_word = 0; m_opnd = 0; m_since = 0;
      m_halt = 1'b0; m_ov = 1'b0; m_od = 0;
    end else begin
      if (m_since < 3) m_since++;
      m_ov = 1'b0;
      if (m_since >= 3 && !m_halt) m_step();
    end
    if (total_cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", total_cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // input driver
  always @(negedge clk) begin
    if (took) begin
      if (in_q.size() > 0) void'(in_q.pop_front());
      in_valid = 1'b0;
      in_gap = in_gap_cfg;
      took = 1'b0;
    end else if (!in_valid && in_q.size() > 0) begin
      if (in_gap > 0) in_gap--;
      else begin
        in_valid = 1'b1;
        in_data = W'(in_q[0]);
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #5;
    if (rst_n && cmp_en) begin
      chk(halted == m_halt, "R11 halted", int'(halted), int'(m_halt));
      chk(in_ready == exp_ready(), "R9 R13 in_ready", int'(in_ready), int'(exp_ready()));
      chk(out_valid == m_ov, "R10 R3 out_valid", int'(out_valid), int'(m_ov));
      if (out_valid) begin
        got.push_back(int'(out_data));
        if (m_ov) chk(int'(out_data) == m_od, "R10 out_data", int'(out_data), m_od);
      end
    end
  end

  task automatic clear_img();
    for (int a = 0; a < IMG; a++) img[a] = (a < DEPTH) ? 0 : enc(K_LDA, 95);
  endtask

  task automatic boot(int gap);
    @(negedge clk);
    cmp_en = 1'b0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_q.delete();
    got.delete();
    took = 1'b0;
    repeat (2) @(negedge clk);
    #5;
    chk(!halted && !out_valid && !in_ready, "R1 reset outputs low",
        int'({halted, out_valid, in_ready}), 0);
    for (int a = 0; a < IMG; a++) begin
      @(negedge clk);
      load_en = 1'b1;
      load_addr = AW'(a);
      load_data = W'(img[a]);
    end
    @(negedge clk);
    load_en = 1'b0;
    for (int a = 0; a < DEPTH; a++) m_mem[a] = img[a] & 'hFFF;
    in_gap_cfg = gap;
    in_gap = gap;
    @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
  endtask

  task automatic run_until_halt(int limit, string tag);
    int n = 0;
    while (!halted && n < limit) begin
      @(negedge clk);
      #6;
      n++;
    end
    chk(halted, tag, int'(halted), 1);
    repeat (20) @(negedge clk);
  endtask

  task automatic check_outputs(string tag);
    chk(got.size() == exp_q.size(), tag, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      chk(got[i] == exp_q[i], tag, got[i], exp_q[i]);
  endtask

  task automatic load_divider();
    clear_img();
    img[0]  = enc(K_LDA, 96);
    img[1]  = enc(K_STA, 97);
    img[2]  = enc(K_IN, 0);
    img[3]  = enc(K_STA, 98);
    img[4]  = enc(K_IN, 0);
    img[5]  = enc(K_STA, 99);
    img[6]  = enc(K_LDA, 98);
    img[7]  = enc(K_SUB, 99);
    img[8]  = enc(K_SKP, 0);
    img[9]  = enc(K_JMP, 15);
    img[10] = enc(K_STA, 98);
    img[11] = enc(K_LDA, 97);
    img[12] = enc(K_ADD, 95);
    img[13] = enc(K_STA, 97);
    img[14] = enc(K_JMP, 6);
    img[15] = enc(K_LDA, 97);
    img[16] = enc(K_OUT, 0);
    img[17] = enc(K_HLT, 0);
    img[95] = 1;
    img[96] = 0;
  endtask

  initial begin
    int n;
    // R14 R7 R4 R5: counting program, inputs 8 and 5
    load_divider();
    boot(0);
    in_q.push_back(8);
    in_q.push_back(5);
    run_until_halt(3000, "R14 halt after 8,5");
    exp_q.delete(); exp_q.push_back(1);
    check_outputs("R14 output for 8,5");

    // R9 R7: same program, delayed inputs 17 and 5
    load_divider();
    boot(6);
    in_q.push_back(17);
    in_q.push_back(5);
    run_until_halt(5000, "R9 halt after 17,5");
    exp_q.delete(); exp_q.push_back(3);
    check_outputs("R7 output for 17,5");

    // R8 R4 R12 R9: countdown with skip-if-zero, wrap, jump above 99
    clear_img();
    img[0]  = enc(K_LDA, 40);
    img[1]  = enc(K_OUT, 0);
    img[2]  = enc(K_SUB, 41);
    img[3]  = enc(K_SKZ, 0);
    img[4]  = enc(K_JMP, 1);
    img[5]  = enc(K_LDA, 42);
    img[6]  = enc(K_ADD, 41);
    img[7]  = enc(K_OUT, 0);
    img[8]  = enc(K_JMP, 100);
    img[40] = 3;
    img[41] = 1;
    img[42] = 'h7FF;
    boot(0);
    in_q.push_back(99);
    run_until_halt(3000, "R12 fetch above 99 halts");
    exp_q.delete();
    exp_q.push_back(3); exp_q.push_back(2); exp_q.push_back(1); exp_q.push_back('h800);
    check_outputs("R8 R4 countdown and wrap");
    chk(in_valid == 1'b1 && in_q.size() == 1, "R9 input not taken without IN",
        in_q.size(), 1);

    // R5 R13 R2: store/load round trip, first ready timing, reserved bit halts
    clear_img();
    img[0]  = enc(K_IN, 0);
    img[1]  = enc(K_STA, 50);
    img[2]  = enc(K_LDA, 51);
    img[3]  = enc(K_OUT, 0);
    img[4]  = enc(K_LDA, 50);
    img[5]  = enc(K_OUT, 0);
    img[6]  = 'h880;
    img[7]  = enc(K_OUT, 0);
    boot(0);
    in_q.push_back('hFF9);
    n = 0;
    while (n < 20) begin
      @(negedge clk);
      n++;
      #6;
      if (in_ready) break;
    end
    chk(n == 5, "R13 first in_ready edge", n, 5);
    run_until_halt(2000, "R2 reserved bit halts");
    exp_q.delete(); exp_q.push_back(0); exp_q.push_back('hFF9);
    check_outputs("R5 store then load");

    // R2 R11: undefined opcode halts at once
    clear_img();
    img[0] = 'hF05;
    img[1] = enc(K_OUT, 0);
    boot(0);
    run_until_halt(200, "R2 opcode 15 halts");
    exp_q.delete();
    check_outputs("R11 no output after halt");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule